// File: doc/BRIEF.md
# Eight-Bit ALU with Decimal Adjust

This block is the arithmetic and logic unit of a small accumulator machine. Each cycle that `en` is high, it takes an operation code, an accumulator operand, a second operand and the incoming carry, decimal and overflow flags. One clock later it presents a registered result, new N, Z, C and V values, and a write-enable for each flag and for the accumulator. The surrounding sequencer uses these enables to decide what it commits. Logic operations leave carry and overflow alone. Compare and bit test leave the accumulator untouched.

Addition and subtraction share one carry-propagate adder. Subtraction feeds the adder the inverted second operand and lets the incoming carry act as "no borrow". When the decimal flag is set, the binary sum is corrected one nibble at a time: the low digit is fixed first, then the high digit. The carry is taken from above the corrected byte.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) gives result = (A + B + C) mod 256. C out is set when the sum, after any decimal correction, reaches 256 or more. N, Z, C, V and the accumulator are all written.
- R2: For add and subtract, V is set when A and B have equal bit 7 and the binary sum's bit 7 differs from A's bit 7. B here is the operand as supplied, not inverted.
- R3: Op 1 (subtract) forms 255 − B + A + C. Its result, carry and write-enables follow the same rules as add.
- R4: With D set, the correction is applied in two steps. Add adds 6 when the sum's low nibble exceeds 9. It then adds 0x60 when bits 7:4 of that value exceed 9. Subtract removes 6 and 0x60 under the same tests. C is set when anything remains above bit 7.
- R5: Op 2 (compare) sets C when A ≥ B, unsigned. N and Z come from (A − B) mod 256. The result port carries that difference. V and the accumulator are not written.
- R6: Ops 3, 4 and 5 (AND, OR, XOR) write the result, N and Z. C and V are not written.
- R7: Op 6 (bit test) sets N to B bit 7 and V to B bit 6. Z is set when (A AND B) is zero. The result port carries A unchanged, and the accumulator and C are not written.
- R8: Ops 7 to 10 work on A. Shift left (7) and rotate left (9) move bit 7 into C. Shift right (8) and rotate right (10) move bit 0 into C. The rotates fill the vacated bit with the old C, and the shifts fill it with 0. N, Z, C and the accumulator are written.
- R9: Op 11 (increment) and op 12 (decrement) give A ± 1 modulo 256 and write only N, Z and the accumulator.
- R10: Op 13 (pass) gives result = B, writes N, Z and the accumulator. For every writing op except bit test, N is result bit 7 and Z is set when the result is zero.
- R11: All outputs change one clock edge after the operation is presented with `en` high, and `res_valid` is then high. After a cycle with `en` low, `res_valid` and all enables are low and `result` holds its previous value.
- R12: While `rst_n` is low, `res_valid`, `result`, every flag output and every enable are zero.
- R13: Ops 14 and 15 give result = A and assert no write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (encodings in R1 to R13) |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| c_in | input | 1 | Incoming carry flag |
| d_in | input | 1 | Decimal mode flag |
| v_in | input | 1 | Incoming overflow flag |
| res_valid | output | 1 | Registered outputs belong to an operation |
| result | output | 8 | Registered result byte |
| n_out | output | 1 | Negative flag value |
| z_out | output | 1 | Zero flag value |
| c_out | output | 1 | Carry flag value |
| v_out | output | 1 | Overflow flag value |
| acc_we | output | 1 | Accumulator write-enable |
| n_we | output | 1 | N write-enable |
| z_we | output | 1 | Z write-enable |
| c_we | output | 1 | C write-enable |
| v_we | output | 1 | V write-enable |

## Verification
The assertions check several rules on every cycle:
- the enable pattern of the logic, compare and bit-test operations;
- the compare carry against an unsigned A ≥ B;
- bit-test flags copied from the operand;
- increment wrap;
- the N/Z rule for all writing operations;
- binary-mode overflow;
- the idle cycle after `en` falls.

Decimal correction, exact carries from corrected sums, subtract results and the rotate fill bits depend on arithmetic that only the bench's model recomputes. The bench sweeps every A value against a spread of B values, with both carry and both decimal settings, to cover these cases.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_BIT  = 4'd6,
    OP_ASL  = 4'd7,
    OP_LSR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_PASS = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic acc;
    logic n;
    logic z;
    logic c;
    logic v;
  } wr_en_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W      = 8,
  parameter bit DEC_EN = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         dec,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         vout
);
  localparam int SW = W + 2;

  logic [SW-1:0] bin_sum;
  logic [W-1:0]  b_eff;
  logic [SW-1:0] adj_sum;

  always_comb begin
    b_eff   = sub ? ~b : b;
    bin_sum = SW'(a) + SW'(b_eff) + SW'(cin);
    // sign rule uses the operand as supplied
    vout    = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ bin_sum[W-1]);
  end

  generate
    if (DEC_EN && (W == 8)) begin : g_bcd
      logic          lo_fix;
      logic          hi_fix;
      logic [SW-1:0] step1;
      always_comb begin
        lo_fix = (bin_sum[3:0] > 4'd9);
        if (lo_fix && dec)
          step1 = sub ? (bin_sum - SW'(6)) : (bin_sum + SW'(6));
        else
          step1 = bin_sum;
        hi_fix = (step1[7:4] > 4'd9);
        if (hi_fix && dec)
          adj_sum = sub ? (step1 - SW'(8'h60)) : (step1 + SW'(8'h60));
        else
          adj_sum = step1;
      end
    end else begin : g_bin
      always_comb adj_sum = bin_sum;
    end
  endgenerate

  always_comb begin
    sum  = adj_sum[W-1:0];
    cout = |adj_sum[SW-1:W];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         left,
  input  logic         rot,
  output logic [W-1:0] res,
  output logic         cout
);
  logic fill;

  always_comb begin
    fill = rot & cin;
    if (left) begin
      res  = {a[W-2:0], fill};
      cout = a[W-1];
    end else begin
      res  = {fill, a[W-1:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W      = 8,
  parameter bit DEC_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         c_in,
  input  logic         d_in,
  input  logic         v_in,
  output logic         res_valid,
  output logic [W-1:0] result,
  output logic         n_out,
  output logic         z_out,
  output logic         c_out,
  output logic         v_out,
  output logic         acc_we,
  output logic         n_we,
  output logic         z_we,
  output logic         c_we,
  output logic         v_we
);
  alu_op_e      op;
  logic [W-1:0] as_sum, lg_res, sh_res, cmp_diff;
  logic         as_c, as_v, sh_c, is_sub, sh_left, sh_rot;

  logic [W-1:0] res_d, res_q;
  logic         n_d, z_d, c_d, v_d;
  logic         n_q, z_q, c_q, v_q;
  wr_en_t       we_d, we_q, we_nx;
  logic         valid_d, valid_q;

  always_comb begin
    op      = alu_op_e'(op_code);
    is_sub  = (op == OP_SUB);
    sh_left = (op == OP_ASL) || (op == OP_ROL);
    sh_rot  = (op == OP_ROL) || (op == OP_ROR);
  end

  alu8_addsub #(.W(W), .DEC_EN(DEC_EN)) u_addsub (
    .a(opnd_a), .b(opnd_b), .cin(c_in), .dec(d_in), .sub(is_sub),
    .sum(as_sum), .cout(as_c), .vout(as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .op(op), .res(lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .a(opnd_a), .cin(c_in), .left(sh_left), .rot(sh_rot),
    .res(sh_res), .cout(sh_c)
  );

  // operation decode and flag formation
  always_comb begin
    cmp_diff = opnd_a - opnd_b;
    res_d    = opnd_a;
    c_d      = c_in;
    v_d      = v_in;
    we_d     = '0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_d = as_sum;
        c_d   = as_c;
        v_d   = as_v;
        we_d  = '{acc: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
      end
      OP_CMP: begin
        res_d = cmp_diff;
        c_d   = (opnd_a >= opnd_b);
        we_d  = '{acc: 1'b0, n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_d = lg_res;
        we_d  = '{acc: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_BIT: begin
        res_d = opnd_a;
        v_d   = opnd_b[W-2];
        we_d  = '{acc: 1'b0, n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_d = sh_res;
        c_d   = sh_c;
        we_d  = '{acc: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
      end
      OP_INC: begin
        res_d = opnd_a + W'(1);
        we_d  = '{acc: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_DEC: begin
        res_d = opnd_a - W'(1);
        we_d  = '{acc: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_PASS: begin
        res_d = opnd_b;
        we_d  = '{acc: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      end
      default: begin
        res_d = opnd_a;
      end
    endcase
    if (op == OP_BIT) begin
      n_d = opnd_b[W-1];
      z_d = (lg_res == '0);
    end else begin
      n_d = res_d[W-1];
      z_d = (res_d == '0);
    end
  end

  // next-state for the output stage
  always_comb begin
    valid_d = en;
    we_nx   = en ? we_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      we_q    <= '0;
      res_q   <= '0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
      c_q     <= 1'b0;
      v_q     <= 1'b0;
    end else begin
      valid_q <= valid_d;
      we_q    <= we_nx;
      if (en) begin
        res_q <= res_d;
        n_q   <= n_d;
        z_q   <= z_d;
        c_q   <= c_d;
        v_q   <= v_d;
      end
    end
  end

  always_comb begin
    res_valid = valid_q;
    result    = res_q;
    n_out     = n_q;
    z_out     = z_q;
    c_out     = c_q;
    v_out     = v_q;
    acc_we    = we_q.acc;
    n_we      = we_q.n;
    z_we      = we_q.z;
    c_we      = we_q.c;
    v_we      = we_q.v;
  end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [3:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         d_in,
  input logic         res_valid,
  input logic [W-1:0] result,
  input logic         n_out,
  input logic         z_out,
  input logic         c_out,
  input logic         v_out,
  input logic         acc_we,
  input logic         n_we,
  input logic         z_we,
  input logic         c_we,
  input logic         v_we
);
  a_r6_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_code == 4'd3 || op_code == 4'd4 || op_code == 4'd5))
      |=> (!c_we && !v_we && acc_we && n_we && z_we));

  a_r5_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'd2)
      |=> (!v_we && !acc_we && c_we && (c_out == ($past(opnd_a) >= $past(opnd_b)))));

  a_r7_bit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'd6)
      |=> (n_out == $past(opnd_b[W-1]) && v_out == $past(opnd_b[W-2])
           && !acc_we && !c_we && result == $past(opnd_a)));

  a_r9_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'd11)
      |=> (result == W'($past(opnd_a) + W'(1)) && !c_we && !v_we));

  a_r10_nz_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code != 4'd6 && op_code < 4'd14)
      |=> (n_out == result[W-1] && z_out == (result == '0)));

  a_r2_overflow_bin: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code == 4'd0 && !d_in)
      |=> (v_out == (($past(opnd_a[W-1]) == $past(opnd_b[W-1]))
                     && (result[W-1] != $past(opnd_a[W-1])))));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (!res_valid && !acc_we && !n_we && !z_we && !c_we && !v_we
               && $stable(result)));

  a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_code >= 4'd14)
      |=> (!acc_we && !n_we && !z_we && !c_we && !v_we && result == $past(opnd_a)));
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, en, c_in, d_in, v_in;
  logic [3:0] op_code;
  logic [7:0] opnd_a, opnd_b, result;
  logic       res_valid, n_out, z_out, c_out, v_out;
  logic       acc_we, n_we, z_we, c_we, v_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .c_in(c_in), .d_in(d_in), .v_in(v_in),
    .res_valid(res_valid), .result(result), .n_out(n_out), .z_out(z_out),
    .c_out(c_out), .v_out(v_out), .acc_we(acc_we), .n_we(n_we),
    .z_we(z_we), .c_we(c_we), .v_we(v_we)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(int op, bit d);
    case (op)
      0:       return d ? "R4 R1" : "R1 R2";
      1:       return d ? "R4 R3" : "R3 R2";
      2:       return "R5";
      3, 4, 5: return "R6";
      6:       return "R7";
      7, 8, 9, 10: return "R8";
      11, 12:  return "R9";
      13:      return "R10";
      default: return "R13";
    endcase
  endfunction

  // reference model: {acc,n,z,c,v} enables, result, flag values
  task automatic model(input int op, input int a, input int b, input bit c, input bit d,
                       output bit [4:0] we, output int r, output bit n, output bit z,
                       output bit co, output bit vo);
    int w;
    we = 5'b0; r = a; co = c; vo = 0;
    case (op)
      0, 1: begin
        w  = (op == 0) ? (a + b + c) : (255 - b + a + c);
        vo = (((a ^ b) & 8'h80) == 0) && (((a ^ w) & 8'h80) != 0);
        if (d) begin
          if ((w & 15) > 9)     w = (op == 0) ? w + 6 : w - 6;
          if ((w & 8'hF0) > 8'h90) w = (op == 0) ? w + 8'h60 : w - 8'h60;
        end
        co = (w >> 8) != 0; r = w & 255; we = 5'b11111;
      end
      2: begin r = (a - b) & 255; co = (a >= b); we = 5'b01110; end
      3: begin r = a & b; we = 5'b11100; end
      4: begin r = a | b; we = 5'b11100; end
      5: begin r = a ^ b; we = 5'b11100; end
      6: begin r = a; vo = (b >> 6) & 1; we = 5'b01101; end
      7: begin r = (a << 1) & 255; co = a >> 7; we = 5'b11110; end
      8: begin r = a >> 1; co = a & 1; we = 5'b11110; end
      9: begin r = ((a << 1) | c) & 255; co = a >> 7; we = 5'b11110; end
      10: begin r = (a >> 1) | (c << 7); co = a & 1; we = 5'b11110; end
      11: begin r = (a + 1) & 255; we = 5'b11100; end
      12: begin r = (a + 255) & 255; we = 5'b11100; end
      13: begin r = b; we = 5'b11100; end
      default: ;
    endcase
    if (op == 6) begin n = (b >> 7) & 1; z = ((a & b) == 0); end
    else begin n = (r >> 7) & 1; z = (r == 0); end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic run(input int op, input int a, input int b, input bit c, input bit d);
    bit [4:0] we; int r; bit n, z, co, vo; bit bad;
    en = 1'b1; op_code = 4'(op); opnd_a = 8'(a); opnd_b = 8'(b);
    c_in = c; d_in = d; v_in = ~c;
    model(op, a, b, c, d, we, r, n, z, co, vo);
    @(negedge clk);
    checks++;
    bad = !res_valid || (result != 8'(r)) || ({acc_we, n_we, z_we, c_we, v_we} != we)
          || (we[3] && n_out != n) || (we[2] && z_out != z)
          || (we[1] && c_out != co) || (we[0] && v_out != vo);
    if (bad) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d d=%0d: got v%0d r=%02h we=%05b nzcv=%0d%0d%0d%0d exp r=%02h we=%05b nzcv=%0d%0d%0d%0d",
               req_of(op, d), op, a, b, c, d, res_valid, result,
               {acc_we, n_we, z_we, c_we, v_we}, n_out, z_out, c_out, v_out,
               r, we, n, z, co, vo);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    summary();
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; en = 1'b0; op_code = 4'd0; opnd_a = 8'h00; opnd_b = 8'h00;
    c_in = 1'b0; d_in = 1'b0; v_in = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (res_valid || result != 8'h00 || {n_out, z_out, c_out, v_out} != 4'b0
        || {acc_we, n_we, z_we, c_we, v_we} != 5'b0) begin
      fails++;
      $display("FAIL R12 reset: got v%0d r=%02h flags=%04b we=%05b exp all zero",
               res_valid, result, {n_out, z_out, c_out, v_out},
               {acc_we, n_we, z_we, c_we, v_we});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: add and subtract, binary and decimal, both carries
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7)
        for (int cd = 0; cd < 4; cd++) begin
          run(0, a, b, cd[0], cd[1]);
          run(1, a, b, cd[0], cd[1]);
        end
    // boundary vectors for R4 and carry
    run(0, 8'h99, 8'h01, 0, 1);
    run(0, 8'h99, 8'h99, 1, 1);
    run(1, 8'h00, 8'h01, 1, 1);
    run(0, 8'hFF, 8'h00, 1, 0);

    // R5 compare
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3) run(2, a, b, a[0], 0);
    run(2, 8'h80, 8'h80, 0, 0);

    // R6 R7 logic and bit test
    for (int op = 3; op <= 6; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17) run(op, a, b, b[0], 0);

    // R8 shifts and rotates
    for (int op = 7; op <= 10; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++) run(op, a, 8'h5A, c[0], 0);

    // R9 R10 R13 inc, dec, pass, reserved
    for (int op = 11; op <= 15; op++)
      for (int a = 0; a < 256; a++) run(op, a, 255 - a, a[1], 0);

    // R11: idle cycle holds result and drops enables
    run(13, 8'h00, 8'h3C, 0, 0);
    held = result;
    en = 1'b0; op_code = 4'd0; opnd_a = 8'hAA; opnd_b = 8'h11;
    @(negedge clk);
    checks++;
    if (res_valid || result != held || {acc_we, n_we, z_we, c_we, v_we} != 5'b0) begin
      fails++;
      $display("FAIL R11 idle: got v%0d r=%02h we=%05b exp v0 r=%02h we=00000",
               res_valid, result, {acc_we, n_we, z_we, c_we, v_we}, held);
    end
    summary();
  end
endmodule